// File: doc/BRIEF.md
# Double-Buffered Cursor Register Bank with Write-Armed Transfer

This block holds the four registers that describe a hardware display cursor: a control word, a screen position, a surface base address and a height-override word. Software writes these through a simple write port into a staging set. Scanout logic reads only a second, live set. The live set takes a snapshot of the staging set on a vertical-blank pulse, but only after the update has been armed.

The arming rules work as follows. Writing the base address arms the transfer. Writing a control word that turns on a cursor that is currently off also arms it. Any other write to a cursor register disarms a pending transfer. As a result, a position-only change stays invisible until the base address is rewritten. A read port returns the staging value of each register and the armed flag. The live position is also presented as two signed coordinates, decoded from its per-axis sign-and-magnitude fields. The live height override is presented as an enable and a line count.

Top module: `cursor_arm_top`

## Requirements
- R1: After reset every live and staging register reads zero, the cursor is disabled and the armed flag is clear.
- R2: A write to the base-address register (address 2) sets the armed flag. On the next cycle with `vblank` high and the flag set, all four staging registers are copied into the live set, and the flag clears in that same cycle.
- R3: A control write (address 0) whose bit 0 (cursor enable) is 1, made while the live control word has bit 0 at 0, sets the armed flag.
- R4: A control write sets no armed flag when its bit 0 is 0, or when the live cursor is already enabled.
- R5: A write to any of addresses 0 to 3 that is not an arming write (R2, R3) clears an armed flag. A following `vblank` then leaves the live set unchanged.
- R6: A position write (address 1) on its own never arms. The live position stays unchanged across `vblank` until an arming write and a `vblank` follow.
- R7: A `vblank` pulse while the flag is clear changes nothing.
- R8: The position word holds X magnitude in bits [MAG_W-1:0] and X sign in bit MAG_W. It holds Y magnitude in bits [2*MAG_W:MAG_W+1] and Y sign in bit 2*MAG_W+1, with sign 1 meaning negative. `curPosX`/`curPosY` give the signed live values, and negative zero reads as 0.
- R9: The height-override word (address 3) holds the line count minus one in bits [HGT_W-1:0] and the enable in bit HGT_W. `curHeightLines` is the live field plus one, and `curHeightEn` is the live enable.
- R10: `rdData` returns the staging value of the register at `rdAddr` (0 control, 1 position, 2 base, 3 height), zero-extended. Address 4 returns the armed flag in bit 0, and addresses 5 to 7 return zero.
- R11: Writes to addresses 4 to 7 change neither the staging registers nor the armed flag.
- R12: When a write and an armed `vblank` fall in the same cycle, the live set takes the staging values from before that write. The flag afterwards is set only if that write is an arming write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 3 | Readback address |
| rdData | output | DATA_W | Readback data (staging values, armed flag) |
| vblank | input | 1 | One-cycle vertical-blank pulse |
| curCtrl | output | CTRL_W | Live control word |
| curEnable | output | 1 | Live cursor enable (control bit 0) |
| curBase | output | BASE_W | Live base address |
| curPosX | output | MAG_W+1 | Live X position, signed two's complement |
| curPosY | output | MAG_W+1 | Live Y position, signed two's complement |
| curHeightEn | output | 1 | Live height-override enable |
| curHeightLines | output | HGT_W+1 | Live height-override line count |
| armed | output | 1 | Update armed and not yet applied |

## Verification
The bench builds the block with DATA_W=16, CTRL_W=4, BASE_W=8, MAG_W=4 and HGT_W=3. With these values the position word is only 10 bits wide, so every sign and magnitude combination of both axes is written, armed, applied and decoded. All 16 height-override words are swept the same way. The arming rules, including same-cycle write-and-blank collisions, are driven from a bench model that tracks the staging set, the live set and the flag.

// File: rtl/cursor_arm_pkg.sv
package cursor_arm_pkg;
  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_POS  = 3'd1;
  localparam logic [2:0] ADR_BASE = 3'd2;
  localparam logic [2:0] ADR_HGT  = 3'd3;
  localparam logic [2:0] ADR_STAT = 3'd4;

  typedef struct packed {
    logic ldCtrl;
    logic ldPos;
    logic ldBase;
    logic ldHgt;
    logic apply;
  } strobes_t;
endpackage

// File: rtl/cursor_arm_ctrl.sv
module cursor_arm_ctrl
  import cursor_arm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic       wrEnableBit,
  input  logic       activeEnable,
  input  logic       vblank,
  output strobes_t   stb,
  output logic       armed
);
  logic armedQ;
  logic regWrite;
  logic armingWrite;

  always_comb begin
    stb = '0;
    if (wrEn) begin
      unique case (wrAddr)
        ADR_CTRL: stb.ldCtrl = 1'b1;
        ADR_POS:  stb.ldPos  = 1'b1;
        ADR_BASE: stb.ldBase = 1'b1;
        ADR_HGT:  stb.ldHgt  = 1'b1;
        default:  ;
      endcase
    end
    stb.apply = vblank && armedQ;
  end

  // R2/R3: arming writes; R5: other register writes disarm
  assign regWrite    = stb.ldCtrl || stb.ldPos || stb.ldBase || stb.ldHgt;
  assign armingWrite = stb.ldBase || (stb.ldCtrl && wrEnableBit && !activeEnable);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (armingWrite) begin
      armedQ <= 1'b1;
    end else if (regWrite || stb.apply) begin
      armedQ <= 1'b0;
    end
  end

  assign armed = armedQ;
endmodule

// File: rtl/cursor_arm_dp.sv
module cursor_arm_dp
  import cursor_arm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int BASE_W = 32,
  parameter int MAG_W  = 12,
  parameter int HGT_W  = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 stb,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [2:0]               rdAddr,
  input  logic                     armed,
  output logic [DATA_W-1:0]        rdData,
  output logic [CTRL_W-1:0]        curCtrl,
  output logic                     curEnable,
  output logic [BASE_W-1:0]        curBase,
  output logic signed [MAG_W:0]    curPosX,
  output logic signed [MAG_W:0]    curPosY,
  output logic                     curHeightEn,
  output logic [HGT_W:0]           curHeightLines
);
  localparam int AX_W  = MAG_W + 1;
  localparam int POS_W = 2 * AX_W;
  localparam int HOV_W = HGT_W + 1;

  logic [CTRL_W-1:0] pendCtrl, actCtrl;
  logic [POS_W-1:0]  pendPos,  actPos;
  logic [BASE_W-1:0] pendBase, actBase;
  logic [HOV_W-1:0]  pendHgt,  actHgt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCtrl <= '0;
      pendPos  <= '0;
      pendBase <= '0;
      pendHgt  <= '0;
    end else begin
      if (stb.ldCtrl) pendCtrl <= wrData[CTRL_W-1:0];
      if (stb.ldPos)  pendPos  <= wrData[POS_W-1:0];
      if (stb.ldBase) pendBase <= wrData[BASE_W-1:0];
      if (stb.ldHgt)  pendHgt  <= wrData[HOV_W-1:0];
    end
  end

  // R12: snapshot takes staging values as they stood before this cycle's write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCtrl <= '0;
      actPos  <= '0;
      actBase <= '0;
      actHgt  <= '0;
    end else if (stb.apply) begin
      actCtrl <= pendCtrl;
      actPos  <= pendPos;
      actBase <= pendBase;
      actHgt  <= pendHgt;
    end
  end

  // R8: per-axis sign-magnitude to two's complement
  logic signed [MAG_W:0] axisVal [2];
  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    logic [MAG_W-1:0] mag;
    logic             neg;
    assign mag = actPos[ax*AX_W +: MAG_W];
    assign neg = actPos[ax*AX_W + MAG_W];
    assign axisVal[ax] = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  assign curPosX        = axisVal[0];
  assign curPosY        = axisVal[1];
  assign curCtrl        = actCtrl;
  assign curEnable      = actCtrl[0];
  assign curBase        = actBase;
  assign curHeightEn    = actHgt[HGT_W];
  assign curHeightLines = {1'b0, actHgt[HGT_W-1:0]} + 1'b1;

  // R10: readback of staging set and armed flag
  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADR_CTRL: rdData[CTRL_W-1:0] = pendCtrl;
      ADR_POS:  rdData[POS_W-1:0]  = pendPos;
      ADR_BASE: rdData[BASE_W-1:0] = pendBase;
      ADR_HGT:  rdData[HOV_W-1:0]  = pendHgt;
      ADR_STAT: rdData[0]          = armed;
      default:  ;
    endcase
  end
endmodule

// File: rtl/cursor_arm_top.sv
module cursor_arm_top
  import cursor_arm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int BASE_W = 32,
  parameter int MAG_W  = 12,
  parameter int HGT_W  = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [2:0]            wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [2:0]            rdAddr,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  vblank,
  output logic [CTRL_W-1:0]     curCtrl,
  output logic                  curEnable,
  output logic [BASE_W-1:0]     curBase,
  output logic signed [MAG_W:0] curPosX,
  output logic signed [MAG_W:0] curPosY,
  output logic                  curHeightEn,
  output logic [HGT_W:0]        curHeightLines,
  output logic                  armed
);
  strobes_t stb;

  cursor_arm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrEnableBit  (wrData[0]),
    .activeEnable (curEnable),
    .vblank       (vblank),
    .stb          (stb),
    .armed        (armed)
  );

  cursor_arm_dp #(
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W),
    .BASE_W (BASE_W),
    .MAG_W  (MAG_W),
    .HGT_W  (HGT_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .wrData         (wrData),
    .rdAddr         (rdAddr),
    .armed          (armed),
    .rdData         (rdData),
    .curCtrl        (curCtrl),
    .curEnable      (curEnable),
    .curBase        (curBase),
    .curPosX        (curPosX),
    .curPosY        (curPosY),
    .curHeightEn    (curHeightEn),
    .curHeightLines (curHeightLines)
  );
endmodule

// File: rtl/cursor_arm_chk.sv
module cursor_arm_chk
  import cursor_arm_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int BASE_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        wrAddr,
  input logic              vblank,
  input logic              armed,
  input logic [CTRL_W-1:0] curCtrl,
  input logic [BASE_W-1:0] curBase
);
  a_r2_base_arms: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr == ADR_BASE |=> armed);

  a_r2_apply_clears: assert property (@(posedge clk) disable iff (!rstN)
    vblank && armed && !wrEn |=> !armed);

  a_r5_write_cancels: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrAddr == ADR_POS || wrAddr == ADR_HGT) |=> !armed);

  a_r7_live_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(vblank && armed) |=> $stable(curBase) && $stable(curCtrl));

  a_r11_stat_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr >= ADR_STAT && !vblank |=> armed == $past(armed));
endmodule

bind cursor_arm_top cursor_arm_chk #(
  .CTRL_W (CTRL_W),
  .BASE_W (BASE_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .vblank  (vblank),
  .armed   (armed),
  .curCtrl (curCtrl),
  .curBase (curBase)
);

// File: tb/tb_cursor_arm_top.sv
module tb_cursor_arm_top;
  localparam int DATA_W = 16;
  localparam int CTRL_W = 4;
  localparam int BASE_W = 8;
  localparam int MAG_W  = 4;
  localparam int HGT_W  = 3;
  localparam int POS_W  = 2 * (MAG_W + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic vblank = 1'b0;
  logic [CTRL_W-1:0] curCtrl;
  logic curEnable;
  logic [BASE_W-1:0] curBase;
  logic signed [MAG_W:0] curPosX, curPosY;
  logic curHeightEn;
  logic [HGT_W:0] curHeightLines;
  logic armed;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cursor_arm_top #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .BASE_W(BASE_W), .MAG_W(MAG_W), .HGT_W(HGT_W)
  ) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .vblank(vblank), .curCtrl(curCtrl),
    .curEnable(curEnable), .curBase(curBase), .curPosX(curPosX), .curPosY(curPosY),
    .curHeightEn(curHeightEn), .curHeightLines(curHeightLines), .armed(armed)
  );

  // bench model
  int mPend [4];
  int mAct  [4];
  bit mArmed;
  int widthOf [4] = '{CTRL_W, POS_W, BASE_W, HGT_W + 1};

  function automatic int axisOf(int word, int ax);
    int mag = (word >> (ax * (MAG_W + 1))) & ((1 << MAG_W) - 1);
    int neg = (word >> (ax * (MAG_W + 1) + MAG_W)) & 1;
    return neg ? -mag : mag;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus; model follows R2, R3, R5, R11, R12
  task automatic cycle(bit doWr, int addr, int data, bit doVbl);
    bit arming, regWr, apply;
    @(negedge clk);
    wrEn = doWr; wrAddr = addr[2:0]; wrData = data[DATA_W-1:0]; vblank = doVbl;
    regWr  = doWr && addr < 4;
    arming = doWr && (addr == 2 || (addr == 0 && data[0] && !mAct[0][0]));
    apply  = doVbl && mArmed;
    if (apply) for (int i = 0; i < 4; i++) mAct[i] = mPend[i];
    if (regWr) mPend[addr] = data & ((1 << widthOf[addr]) - 1);
    if (arming) mArmed = 1'b1;
    else if (regWr || apply) mArmed = 1'b0;
    @(negedge clk);
    wrEn = 1'b0; vblank = 1'b0;
  endtask

  task automatic wr(int addr, int data);
    cycle(1'b1, addr, data, 1'b0);
  endtask

  task automatic vbl();
    cycle(1'b0, 0, 0, 1'b1);
  endtask

  task automatic checkLive(string req);
    check({req, " ctrl"}, int'(curCtrl), mAct[0]);
    check({req, " enable"}, int'(curEnable), mAct[0] & 1);
    check({req, " base"}, int'(curBase), mAct[2]);
    check({req, " posX"}, int'(curPosX), axisOf(mAct[1], 0));
    check({req, " posY"}, int'(curPosY), axisOf(mAct[1], 1));
    check({req, " hgtEn"}, int'(curHeightEn), (mAct[3] >> HGT_W) & 1);
    check({req, " hgtLines"}, int'(curHeightLines), (mAct[3] & ((1 << HGT_W) - 1)) + 1);
    check({req, " armed"}, int'(armed), int'(mArmed));
  endtask

  task automatic checkRead(string req, int addr);
    int exp;
    rdAddr = addr[2:0];
    #1;
    if (addr < 4) exp = mPend[addr];
    else if (addr == 4) exp = int'(mArmed);
    else exp = 0;
    check(req, int'(rdData), exp);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin mPend[i] = 0; mAct[i] = 0; end
    mArmed = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkLive("R1");
    for (int a = 0; a < 8; a++) checkRead("R1 readback", a);

    // R10: staging readback, status bit
    wr(0, 16'hA); wr(1, 16'h2F3); wr(2, 16'h5C);
    checkRead("R10 status armed", 4);
    wr(3, 16'hB);
    for (int a = 0; a < 8; a++) checkRead("R10 readback", a);

    // R5: height write disarmed the base write; vblank leaves live set alone
    vbl();
    checkLive("R5 cancelled by height write");

    // R2: base write arms, vblank copies all four
    wr(2, 16'h77);
    check("R2 armed after base write", int'(armed), 1);
    vbl();
    checkLive("R2 transfer");
    check("R2 flag cleared", int'(armed), 0);

    // R8: exhaustive position sweep
    for (int v = 0; v < (1 << POS_W); v++) begin
      wr(1, v);
      wr(2, v & 8'hFF);
      vbl();
      check("R8 posX", int'(curPosX), axisOf(v, 0));
      check("R8 posY", int'(curPosY), axisOf(v, 1));
    end

    // R9: height-override sweep
    for (int h = 0; h < (1 << (HGT_W + 1)); h++) begin
      wr(3, h);
      wr(2, h);
      vbl();
      check("R9 hgtEn", int'(curHeightEn), (h >> HGT_W) & 1);
      check("R9 hgtLines", int'(curHeightLines), (h & ((1 << HGT_W) - 1)) + 1);
    end

    // R6: position alone never arms
    wr(1, 16'h155);
    check("R6 pos write not armed", int'(armed), 0);
    vbl();
    checkLive("R6 live pos unchanged");

    // R3: enabling control write arms when live cursor is off
    wr(0, 16'h0); wr(2, 16'h10); vbl();
    check("R3 precondition disabled", int'(curEnable), 0);
    wr(0, 16'h5);
    check("R3 enable write arms", int'(armed), 1);
    vbl();
    checkLive("R3 enabled after vblank");

    // R4: control writes that do not arm
    wr(0, 16'h3);
    check("R4 already enabled no arm", int'(armed), 0);
    wr(0, 16'h2);
    check("R4 enable bit clear no arm", int'(armed), 0);
    vbl();
    checkLive("R4 live unchanged");

    // R5: non-arming control write cancels armed base write
    wr(2, 16'h99);
    wr(0, 16'h7);
    check("R5 ctrl write cancels", int'(armed), 0);
    vbl();
    checkLive("R5 live unchanged");

    // R11: writes to 4..7 are ignored
    wr(2, 16'h42);
    for (int a = 4; a < 8; a++) begin
      wr(a, 16'hFFFF);
      check("R11 armed kept", int'(armed), 1);
      for (int r = 0; r < 5; r++) checkRead("R11 staging kept", r);
    end

    // R7: vblank with flag clear changes nothing
    vbl();
    checkLive("R7 applied");
    vbl();
    checkLive("R7 idle vblank");

    // R12: write coinciding with armed vblank
    wr(2, 16'h31);
    cycle(1'b1, 1, 16'h3FF, 1'b1);
    checkLive("R12 pre-write snapshot, non-arming");
    checkRead("R12 new staging pos", 1);
    wr(1, 16'h021);
    wr(2, 16'h32);
    cycle(1'b1, 2, 16'h33, 1'b1);
    checkLive("R12 arming write rearms");
    vbl();
    checkLive("R12 second transfer");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule